// File: doc/BRIEF.md
# I2C Slave Front End with Paired Register Access

This block is the serial protocol engine of an I2C target that fronts a bank of eight byte-wide registers. It oversamples the SCL and SDA lines on a fast system clock and finds bus conditions and clock edges. It responds to one 7-bit address, built from a fixed prefix with three strap inputs placed at a configurable bit position. After the address comes a command byte that sets a register pointer. Data bytes then flow into or out of the bank.

Consecutive data bytes do not walk through the register map. They bounce between the two registers of a pair, which differ only in the pointer LSB, for as long as the master keeps transferring. The pointer survives the end of a transaction, so a later read without a command byte resumes at the last pointer. The engine drives SDA only as an open-drain pull-down enable. The register bank sits outside the block, behind a write strobe and a combinational read-data input.

Top module: `i2c_pair_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state. A rising SDA while SCL is high (STOP) returns the engine to idle with SDA released.
- R2: The first byte after START is taken MSB first. Its upper seven bits are compared with the own address: ADDR_PREFIX with bits PIN_LSB+2..PIN_LSB replaced by `addr_sel_i`, where `addr_sel_i[0]` goes to bit PIN_LSB. On a match the engine pulls SDA low through the ninth clock. Bit 0 of the byte selects read (1) or write (0).
- R3: A non-matching address gets no acknowledge. SDA is not driven and nothing is written until the next START.
- R4: In a write, the byte after the address is acknowledged and its low three bits load the pointer. Its upper bits are ignored, and it causes no write strobe.
- R5: Each further write byte is acknowledged. On the falling SCL that ends its acknowledge clock, it is committed by a single-cycle `wr_stb_o` to `wr_idx_o` equal to the pointer. The pointer LSB then toggles, with no limit on the byte count.
- R6: In a read, a byte is loaded from `rd_data_i` at `reg_idx_o` on the falling SCL that ends the preceding acknowledge, with a one-cycle `rd_stb_o`. It is shifted out MSB first, and SDA is pulled low for each 0 bit.
- R7: A master ACK toggles the pointer LSB and the next byte follows. A master NACK ends the read: SDA stays released, no further byte is loaded and the pointer is not toggled.
- R8: The pointer resets to 0 and keeps its value between transactions. A read with no command byte starts at the last pointer.
- R9: A STOP or START inside a byte discards the partial byte without a write. Bytes committed before it stay in effect.
- R10: The SDA pull-down enable is asserted only after a falling SCL, while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus value) |
| addr_sel_i | input | 3 | Strap bits placed into the own address |
| rd_data_i | input | 8 | Bank contents at `reg_idx_o` |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_idx_o | output | REG_AW | Current register pointer |
| rd_stb_o | output | 1 | One-cycle pulse when a read byte is loaded |
| wr_stb_o | output | 1 | One-cycle write commit pulse |
| wr_idx_o | output | REG_AW | Register written by `wr_stb_o` |
| wr_data_o | output | 8 | Byte written by `wr_stb_o` |

## Verification
The address comparator is swept over all 128 addresses with one strap value, and then over every strap value, each paired with an address differing in one strap bit. This shows whether matching depends on all seven bits and on the strap placement. Writes and reads are repeated for each of the eight command values, with and without junk in the command's upper bits, and with three- and four-byte bursts. These separate pair alternation from auto-increment and show that the pointer persists. Transfers broken by STOP or START in mid-byte, a read with no command byte, and traffic to a foreign address isolate the discard, resume and ignore behaviour.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
   localparam int BYTE_W = 8;
   localparam int ADR_W  = 7;
   localparam int SEL_W  = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_SACK,
      ST_TX,
      ST_MACK
   } eng_state_t;

   typedef enum logic [1:0] {
      RX_ADDR,
      RX_CMD,
      RX_DATA
   } rx_kind_t;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
   import i2c_pair_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev
);
   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic scl_d;
   logic sda_d;
   logic scl_s;
   logic sda_s;

   // idle bus is high on both lines
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign scl_s = scl_sh[SYNC_STAGES-1];
   assign sda_s = sda_sh[SYNC_STAGES-1];

   always_comb begin
      ev.scl      = scl_s;
      ev.sda      = sda_s;
      ev.scl_rise = scl_s & ~scl_d;
      ev.scl_fall = ~scl_s & scl_d;
      ev.start    = scl_s & scl_d & sda_d & ~sda_s;
      ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
   end
endmodule

// File: rtl/i2c_pair_ptr.sv
module i2c_pair_ptr #(
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [REG_AW-1:0] load_val,
   input  logic              flip,
   output logic [REG_AW-1:0] ptr
);
   localparam logic [REG_AW-1:0] PAIR_BIT = REG_AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (flip) ptr <= ptr ^ PAIR_BIT;
   end
endmodule

// File: rtl/i2c_pair_fsm.sv
module i2c_pair_fsm
   import i2c_pair_pkg::*;
#(
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic [ADR_W-1:0]  own_addr,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic [REG_AW-1:0] ptr,
   output logic              ptr_load,
   output logic [REG_AW-1:0] ptr_load_val,
   output logic              ptr_flip,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [REG_AW-1:0] wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_stb,
   output eng_state_t        st
);
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

   rx_kind_t          kind;
   logic [3:0]        cnt;
   logic [BYTE_W-1:0] shreg;
   logic              rw;
   logic              mack;
   logic              addr_hit;

   assign addr_hit = (shreg[BYTE_W-1:1] == own_addr);

   // pointer commands are decoded from the same events the state register uses
   always_comb begin
      ptr_load     = (st == ST_SACK) && ev.scl_fall && (kind == RX_CMD);
      ptr_load_val = shreg[REG_AW-1:0];
      ptr_flip     = ((st == ST_SACK) && ev.scl_fall && (kind == RX_DATA)) ||
                     ((st == ST_MACK) && ev.scl_rise && !ev.sda);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         kind    <= RX_ADDR;
         cnt     <= '0;
         shreg   <= '0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         sda_oe  <= 1'b0;
         wr_stb  <= 1'b0;
         rd_stb  <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (ev.start) begin
            st     <= ST_RX;
            kind   <= RX_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (ev.scl_rise && cnt < LAST_BIT) begin
                     shreg <= {shreg[BYTE_W-2:0], ev.sda};
                     cnt   <= cnt + 4'd1;
                  end else if (ev.scl_fall && cnt == LAST_BIT) begin
                     if (kind == RX_ADDR && !addr_hit) begin
                        st <= ST_IDLE;
                     end else begin
                        st     <= ST_SACK;
                        sda_oe <= 1'b1;
                        if (kind == RX_ADDR) rw <= shreg[0];
                     end
                  end
               end
               ST_SACK: begin
                  if (ev.scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     unique case (kind)
                        RX_ADDR: begin
                           if (rw) begin
                              st     <= ST_TX;
                              shreg  <= rd_data;
                              rd_stb <= 1'b1;
                              sda_oe <= ~rd_data[BYTE_W-1];
                           end else begin
                              st   <= ST_RX;
                              kind <= RX_CMD;
                           end
                        end
                        RX_CMD: begin
                           st   <= ST_RX;
                           kind <= RX_DATA;
                        end
                        default: begin
                           st      <= ST_RX;
                           wr_stb  <= 1'b1;
                           wr_idx  <= ptr;
                           wr_data <= shreg;
                        end
                     endcase
                  end
               end
               ST_TX: begin
                  if (ev.scl_fall) begin
                     if (cnt == LAST_BIT - 4'd1) begin
                        st     <= ST_MACK;
                        sda_oe <= 1'b0;
                     end else begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shreg[BYTE_W-2];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_MACK: begin
                  if (ev.scl_rise) begin
                     mack <= ~ev.sda;
                  end else if (ev.scl_fall) begin
                     if (mack) begin
                        st     <= ST_TX;
                        cnt    <= '0;
                        shreg  <= rd_data;
                        rd_stb <= 1'b1;
                        sda_oe <= ~rd_data[BYTE_W-1];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_pair_slave.sv
module i2c_pair_slave
   import i2c_pair_pkg::*;
#(
   parameter logic [6:0] ADDR_PREFIX = 7'h20,
   parameter int         PIN_LSB     = 0,
   parameter int         SYNC_STAGES = 2,
   parameter int         REG_AW      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [SEL_W-1:0]  addr_sel_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              sda_oe_o,
   output logic [REG_AW-1:0] reg_idx_o,
   output logic              rd_stb_o,
   output logic              wr_stb_o,
   output logic [REG_AW-1:0] wr_idx_o,
   output logic [BYTE_W-1:0] wr_data_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PIN_LSB < 0 || PIN_LSB > ADR_W - SEL_W) begin : g_bad_pin
      $error("PIN_LSB places strap bits outside the address");
   end
   if (REG_AW < 1 || REG_AW > BYTE_W) begin : g_bad_aw
      $error("REG_AW must fit in the command byte");
   end

   logic [ADR_W-1:0] own_addr;
   for (genvar b = 0; b < ADR_W; b++) begin : g_abit
      if (b >= PIN_LSB && b < PIN_LSB + SEL_W) begin : g_strap
         assign own_addr[b] = addr_sel_i[b - PIN_LSB];
      end else begin : g_fixed
         assign own_addr[b] = ADDR_PREFIX[b];
      end
   end

   bus_ev_t           ev;
   logic              ptr_load;
   logic              ptr_flip;
   logic [REG_AW-1:0] ptr_load_val;
   logic [REG_AW-1:0] ptr;
   eng_state_t        st;
   logic              scl_sync;
   logic              bus_start;
   logic              bus_stop;

   i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   i2c_pair_ptr #(.REG_AW(REG_AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (ptr_load_val),
      .flip     (ptr_flip),
      .ptr      (ptr)
   );

   i2c_pair_fsm #(.REG_AW(REG_AW)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev           (ev),
      .own_addr     (own_addr),
      .rd_data      (rd_data_i),
      .ptr          (ptr),
      .ptr_load     (ptr_load),
      .ptr_load_val (ptr_load_val),
      .ptr_flip     (ptr_flip),
      .sda_oe       (sda_oe_o),
      .wr_stb       (wr_stb_o),
      .wr_idx       (wr_idx_o),
      .wr_data      (wr_data_o),
      .rd_stb       (rd_stb_o),
      .st           (st)
   );

   assign reg_idx_o = ptr;
   assign scl_sync  = ev.scl;
   assign bus_start = ev.start;
   assign bus_stop  = ev.stop;
endmodule

// File: rtl/i2c_pair_slave_chk.sv
module i2c_pair_slave_chk
   import i2c_pair_pkg::*;
#(
   parameter int REG_AW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_sync,
   input logic              bus_start,
   input logic              bus_stop,
   input logic              sda_oe,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [REG_AW-1:0] wr_idx,
   input logic [REG_AW-1:0] reg_idx,
   input eng_state_t        st
);
   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_oe);

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   assert_wr_then_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (reg_idx == (wr_idx ^ REG_AW'(1))));

   assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);

   assert_rd_in_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> (st == ST_TX));

   assert_start_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> (!wr_stb && !rd_stb));

   assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_sync));
endmodule

bind i2c_pair_slave i2c_pair_slave_chk #(.REG_AW(REG_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_sync  (scl_sync),
   .bus_start (bus_start),
   .bus_stop  (bus_stop),
   .sda_oe    (sda_oe_o),
   .wr_stb    (wr_stb_o),
   .rd_stb    (rd_stb_o),
   .wr_idx    (wr_idx_o),
   .reg_idx   (reg_idx_o),
   .st        (u_fsm.st)
);

// File: tb/tb_i2c_pair_slave.sv
module tb_i2c_pair_slave;
   localparam logic [6:0] PFX = 7'h20;
   localparam int         LSB = 0;
   localparam int         Q   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [2:0] sel = 3'd5;
   logic       sda_oe, rd_stb, wr_stb;
   logic [2:0] reg_idx, wr_idx;
   logic [7:0] wr_data, rd_data;
   wire        sda_bus = m_sda & ~sda_oe;

   logic [7:0] bank [8];
   logic [7:0] expb [8];
   int n_chk = 0, n_err = 0, n_wr = 0, n_rd = 0, n_bad_oe = 0;
   logic oe_prev = 1'b0;

   assign rd_data = bank[reg_idx];

   i2c_pair_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .addr_sel_i(sel), .rd_data_i(rd_data), .sda_oe_o(sda_oe),
      .reg_idx_o(reg_idx), .rd_stb_o(rd_stb), .wr_stb_o(wr_stb),
      .wr_idx_o(wr_idx), .wr_data_o(wr_data)
   );

   function automatic logic [7:0] init_val(input int i);
      return 8'(i * 37 + 11);
   endfunction

   function automatic logic [6:0] own(input logic [2:0] s);
      return (PFX & ~(7'h7 << LSB)) | (7'(s) << LSB);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) bank[i] <= init_val(i);
      end else begin
         if (wr_stb) begin
            bank[wr_idx] <= wr_data;
            n_wr <= n_wr + 1;
         end
         if (rd_stb) n_rd <= n_rd + 1;
         // R10: enable may only come up while the line clock is low
         if (sda_oe && !oe_prev && m_scl) n_bad_oe <= n_bad_oe + 1;
      end
      oe_prev <= sda_oe;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_sda = 1'b1; wq(Q);
   endtask

   task automatic write_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wq(Q);
         m_scl = 1'b1; wq(2 * Q);
         m_scl = 1'b0; wq(Q);
      end
   endtask

   task automatic write_byte(input logic [7:0] b, output bit ack);
      write_bits(b, 8);
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      ack = (sda_bus == 1'b0);
      wq(Q);
      m_scl = 1'b0; wq(Q);
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q);
         m_scl = 1'b1; wq(Q);
         b[i] = sda_bus;
         wq(Q);
         m_scl = 1'b0; wq(Q);
      end
      m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
      m_scl = 1'b1; wq(2 * Q);
      m_scl = 1'b0; wq(Q);
      m_sda = 1'b1;
   endtask

   task automatic check_bank(input string req);
      for (int i = 0; i < 8; i++) check(req, bank[i], expb[i]);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] rb;
      logic [2:0] exp_ptr;
      int wr0, rd0;

      wq(5);
      check("R1 reset sda_oe", sda_oe, 0);
      check("R8 reset pointer", reg_idx, 0);
      check("R5 reset wr_stb", wr_stb, 0);
      rst_n = 1'b1;
      wq(5);
      for (int i = 0; i < 8; i++) expb[i] = init_val(i);
      exp_ptr = 3'd0;

      // R2 R3: full address sweep with straps fixed
      for (int a = 0; a < 128; a++) begin
         bus_start();
         write_byte({7'(a), 1'b0}, ack);
         bus_stop();
         check(a == int'(own(sel)) ? "R2 address match" : "R3 address mismatch",
               ack, (7'(a) == own(sel)) ? 1 : 0);
      end
      check("R3 no write from address sweep", n_wr, 0);

      // R2: every strap value, plus neighbour with one strap bit flipped
      for (int s = 0; s < 8; s++) begin
         sel = 3'(s);
         bus_start(); write_byte({own(3'(s)), 1'b0}, ack); bus_stop();
         check("R2 strap match", ack, 1);
         bus_start(); write_byte({own(3'(s) ^ 3'd1), 1'b0}, ack); bus_stop();
         check("R3 strap mismatch", ack, 0);
      end
      sel = 3'd5;

      // R3: foreign address followed by command and data bytes
      wr0 = n_wr;
      bus_start();
      write_byte({own(sel) ^ 7'h40, 1'b0}, ack); check("R3 foreign addr", ack, 0);
      write_byte(8'h02, ack);                    check("R3 foreign cmd", ack, 0);
      write_byte(8'h5A, ack);                    check("R3 foreign data", ack, 0);
      bus_stop();
      check("R3 no write", n_wr, wr0);
      check_bank("R3 bank untouched");

      // R4 R5: write bursts for every command, plain and with junk upper bits
      for (int c = 0; c < 8; c++) begin
         for (int v = 0; v < 2; v++) begin
            logic [7:0] d1, d2, d3, cmd;
            d1 = 8'(c * 16 + v * 8 + 1);
            d2 = ~d1;
            d3 = d1 ^ 8'hA5;
            cmd = (v == 1) ? (8'hF8 | 8'(c)) : 8'(c);
            wr0 = n_wr;
            bus_start();
            write_byte({own(sel), 1'b0}, ack); check("R2 write addr ack", ack, 1);
            write_byte(cmd, ack);              check("R4 cmd ack", ack, 1);
            check("R4 cmd loads pointer", reg_idx, c);
            check("R4 cmd no write", n_wr, wr0);
            write_byte(d1, ack); check("R5 data ack", ack, 1);
            write_byte(d2, ack); check("R5 data ack", ack, 1);
            write_byte(d3, ack); check("R5 data ack", ack, 1);
            bus_stop();
            expb[c] = d1; expb[c ^ 1] = d2; expb[c] = d3;
            exp_ptr = 3'(c) ^ 3'd1;
            check("R5 three commits", n_wr, wr0 + 3);
            check("R5 pointer after burst", reg_idx, exp_ptr);
            check_bank("R5 pair alternation");
         end
      end

      // R6 R7: command, repeated START, four-byte read ending in NACK
      for (int c = 0; c < 8; c++) begin
         rd0 = n_rd;
         bus_start();
         write_byte({own(sel), 1'b0}, ack);
         write_byte(8'(c), ack);
         bus_start();
         write_byte({own(sel), 1'b1}, ack); check("R2 read addr ack", ack, 1);
         read_byte(1'b1, rb); check("R6 read byte 0", rb, expb[c]);
         read_byte(1'b1, rb); check("R7 read byte 1 partner", rb, expb[c ^ 1]);
         read_byte(1'b1, rb); check("R7 read byte 2", rb, expb[c]);
         read_byte(1'b0, rb); check("R7 read byte 3", rb, expb[c ^ 1]);
         check("R7 released after NACK", sda_oe, 0);
         check("R7 no load after NACK", n_rd, rd0 + 4);
         bus_stop();
         exp_ptr = 3'(c) ^ 3'd1;
         check("R8 pointer after read", reg_idx, exp_ptr);
      end

      // R8: read with no command byte resumes at last pointer
      bus_start();
      write_byte({own(sel), 1'b1}, ack);
      read_byte(1'b0, rb);
      bus_stop();
      check("R8 resume read", rb, expb[exp_ptr]);
      check("R8 pointer kept", reg_idx, exp_ptr);

      // R9: STOP inside a byte
      wr0 = n_wr;
      bus_start();
      write_byte({own(sel), 1'b0}, ack);
      write_byte(8'h01, ack);
      write_byte(8'h3C, ack);
      write_bits(8'hC3, 4);
      bus_stop();
      expb[1] = 8'h3C;
      check("R9 only full byte committed", n_wr, wr0 + 1);
      check("R9 pointer after partial", reg_idx, 0);
      check_bank("R9 partial discarded");

      // R1 R9: repeated START inside a byte restarts the address phase
      wr0 = n_wr;
      bus_start();
      write_byte({own(sel), 1'b0}, ack);
      write_byte(8'h02, ack);
      write_bits(8'hFF, 3);
      bus_start();
      write_byte({own(sel), 1'b0}, ack); check("R1 restart address ack", ack, 1);
      write_byte(8'h04, ack);
      write_byte(8'h77, ack);
      bus_stop();
      expb[4] = 8'h77;
      check("R1 one commit after restart", n_wr, wr0 + 1);
      check("R1 pointer after restart", reg_idx, 5);
      check("R1 released after STOP", sda_oe, 0);
      check_bank("R9 restart discards partial");

      check("R10 enable rises only with SCL low", n_bad_oe, 0);

      summary();
      $finish;
   end
endmodule